// File: doc/BRIEF.md
# Recirculating Serial Word Store

This block keeps a set of fixed-width words in a single closed bit-serial loop. One bit leaves the tap on every clock and is written back into the far end of the loop, so the stored contents circulate without end. A word counter and a bit counter follow which word, and which bit of it, sits at the tap. Each word carries a number/order flag in bit 31, a sign in bit 30 and a magnitude in bits 29:0. The store keeps all 32 bits exactly as written and does not interpret them.

A client asks for one word by its address, either to read it or to overwrite it. The access then waits until that word reaches the tap. The wait is between 0 and 31 word times, depending on where the loop happens to be. During the word's 32 clocks a valid strobe is high. In a read the bits stream out least significant first. In a write the serial input takes the place of the circulating bits. One clock after the last bit, a done pulse marks the end of the access.

Top module: `serial_loop_store`

## Requirements
- R1: The loop holds 32 words of 32 bits, selected by a 5-bit word address. A word written at an address reads back with all 32 bits (flag in bit 31, sign in bit 30, magnitude in bits 29:0) unchanged.
- R2: After reset every word reads as zero, and `bit_valid_o` and `done_o` are low.
- R3: The loop shifts one bit per clock with a period of 1024 clocks. Words that are not being written keep their value however many periods pass.
- R4: Counting clocks with reset released from 0, bit 0 of word 0 is at the tap at count 0. Bit b of word w is at the tap whenever the count modulo 1024 equals 32*w+b. `bit_valid_o` is high only while the addressed word is at the tap.
- R5: An access accepted at the clock edge that brings the count to c starts at the first count c' >= c with c' mod 1024 = 32*addr. The start can therefore come in the same clock as acceptance, or as late as 1023 clocks after it.
- R6: A read raises `bit_valid_o` for exactly 32 consecutive clocks. During them `rd_bit_o` presents word bits 0 through 31, least significant first.
- R7: In a write, `wr_bit_i` is sampled at the end of each of the 32 valid clocks and stored as word bits 0 through 31 in that order. No other word changes, and `wr_bit_i` has no effect during reads or while idle.
- R8: `done_o` is high for exactly one clock, the clock right after the last valid bit.
- R9: A request seen at a clock edge with no access pending is accepted, and `we_i` chooses write (1) or read (0). A request made while an access is pending is ignored: it produces no transfer, no done pulse and no change to storage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, sampled when idle |
| we_i | input | 1 | 1 for write, 0 for read |
| addr_i | input | 5 | Word address |
| wr_bit_i | input | 1 | Serial write data, LSB first |
| rd_bit_o | output | 1 | Serial read data, LSB first, zero when not valid |
| bit_valid_o | output | 1 | High during the addressed word's 32 clocks |
| done_o | output | 1 | One-clock pulse after the last bit |

## Verification
Each access is timed against a loop position that the bench derives only from the clock count since reset. This separates a correct wait from an off-by-one start, and the special cases are the zero-wait case, where the request lands just as the word arrives, and the maximum-wait case, where it lands one bit too late. Dense, sparse, all-ones and sign-and-flag-only patterns in words 0, 17 and 31, followed by a full sweep of distinct values read back after idle loop periods, separate bit-order errors, writes to the wrong word and recirculation faults. A write request injected while a read is waiting shows whether pending requests and serial input during reads are truly ignored.

// File: rtl/serial_loop_pkg.sv
package serial_loop_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PEND = 2'd1,
        ST_XFER = 2'd2
    } acc_state_e;
endpackage

// File: rtl/loop_position.sv
module loop_position #(
    parameter int WORDS = 32,
    parameter int WIDTH = 32,
    localparam int AW = $clog2(WORDS),
    localparam int BW = $clog2(WIDTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [BW-1:0] bit_cnt,
    output logic [AW-1:0] word_cnt
);
    localparam logic [BW-1:0] BIT_LAST  = BW'(WIDTH - 1);
    localparam logic [AW-1:0] WORD_LAST = AW'(WORDS - 1);

    typedef struct packed {
        logic [BW-1:0] bit_n;
        logic [AW-1:0] word_n;
    } pos_t;

    pos_t pos_d, pos_q;

    always_comb begin
        pos_d = pos_q;
        if (pos_q.bit_n == BIT_LAST) begin
            pos_d.bit_n  = '0;
            pos_d.word_n = (pos_q.word_n == WORD_LAST) ? '0 : pos_q.word_n + 1'b1;
        end else begin
            pos_d.bit_n = pos_q.bit_n + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pos_q <= '0;
        else        pos_q <= pos_d;
    end

    assign bit_cnt  = pos_q.bit_n;
    assign word_cnt = pos_q.word_n;

    // R4
    word_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_cnt == BIT_LAST) |=> (bit_cnt == '0 &&
            word_cnt == ((($past(word_cnt)) == WORD_LAST) ? '0 : AW'($past(word_cnt) + 1'b1))));

    // R4
    bit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_cnt != BIT_LAST) |=> (word_cnt == $past(word_cnt)));
endmodule

// File: rtl/delay_loop.sv
module delay_loop #(
    parameter int DEPTH = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wr_bit,
    output logic tap
);
    logic [DEPTH-1:0] line_d, line_q;
    logic             feed;

    always_comb begin
        feed   = wr_en ? wr_bit : line_q[0];
        line_d = {feed, line_q[DEPTH-1:1]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) line_q <= '0;
        else        line_q <= line_d;
    end

    assign tap = line_q[0];

    // R3
    recirc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> (line_q[DEPTH-1] == $past(tap)));

    // R7
    overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (line_q[DEPTH-1] == $past(wr_bit)));
endmodule

// File: rtl/access_ctrl.sv
module access_ctrl
    import serial_loop_pkg::*;
#(
    parameter int WORDS = 32,
    parameter int WIDTH = 32,
    localparam int AW = $clog2(WORDS),
    localparam int BW = $clog2(WIDTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [BW-1:0] bit_cnt,
    input  logic [AW-1:0] word_cnt,
    output logic          xfer,
    output logic          wr_en,
    output logic          done
);
    localparam logic [BW-1:0] BIT_LAST = BW'(WIDTH - 1);

    typedef struct packed {
        acc_state_e    st;
        logic          we;
        logic [AW-1:0] addr;
        logic          done;
    } ctrl_t;

    ctrl_t ctl_d, ctl_q;
    logic  at_start;

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        at_start   = (word_cnt == ctl_q.addr) && (bit_cnt == '0);
        xfer       = (ctl_q.st == ST_XFER) || (ctl_q.st == ST_PEND && at_start);
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (req) begin
                    ctl_d.st   = ST_PEND;
                    ctl_d.we   = we;
                    ctl_d.addr = addr;
                end
            end
            ST_PEND: begin
                if (at_start) ctl_d.st = ST_XFER;
            end
            ST_XFER: begin
                if (bit_cnt == BIT_LAST) begin
                    ctl_d.st   = ST_IDLE;
                    ctl_d.done = 1'b1;
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
        wr_en = xfer && ctl_q.we;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{st: ST_IDLE, we: 1'b0, addr: '0, done: 1'b0};
        else        ctl_q <= ctl_d;
    end

    assign done = ctl_q.done;

    // R4
    xfer_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer |-> (word_cnt == ctl_q.addr));

    // R6
    xfer_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(xfer) |-> (bit_cnt == '0));

    // R8
    done_follows_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && bit_cnt == BIT_LAST) |=> done);

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st != ST_IDLE) |=> ($stable(ctl_q.addr) && $stable(ctl_q.we)));
endmodule

// File: rtl/serial_loop_store.sv
module serial_loop_store #(
    parameter int WORDS = 32,
    parameter int WIDTH = 32,
    localparam int AW = $clog2(WORDS),
    localparam int BW = $clog2(WIDTH),
    localparam int DEPTH = WORDS * WIDTH
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_i,
    input  logic          we_i,
    input  logic [AW-1:0] addr_i,
    input  logic          wr_bit_i,
    output logic          rd_bit_o,
    output logic          bit_valid_o,
    output logic          done_o
);
    logic [BW-1:0] bit_cnt;
    logic [AW-1:0] word_cnt;
    logic          xfer;
    logic          wr_en;
    logic          tap;

    loop_position #(.WORDS(WORDS), .WIDTH(WIDTH)) pos_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_cnt  (bit_cnt),
        .word_cnt (word_cnt)
    );

    access_ctrl #(.WORDS(WORDS), .WIDTH(WIDTH)) ctrl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req_i),
        .we       (we_i),
        .addr     (addr_i),
        .bit_cnt  (bit_cnt),
        .word_cnt (word_cnt),
        .xfer     (xfer),
        .wr_en    (wr_en),
        .done     (done_o)
    );

    delay_loop #(.DEPTH(DEPTH)) loop_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_bit (wr_bit_i),
        .tap    (tap)
    );

    assign bit_valid_o = xfer;
    assign rd_bit_o    = xfer & tap;

    // R6
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_valid_o |-> !rd_bit_o);
endmodule

// File: tb/serial_loop_store_tb_top.sv
module serial_loop_store_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_i = 1'b0;
    logic       we_i = 1'b0;
    logic [4:0] addr_i = '0;
    logic       wr_bit_i = 1'b0;
    logic       rd_bit_o, bit_valid_o, done_o;

    always #2 clk = ~clk;

    serial_loop_store dut_i (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
        .wr_bit_i(wr_bit_i), .rd_bit_o(rd_bit_o), .bit_valid_o(bit_valid_o), .done_o(done_o)
    );

    int n_tests = 0;
    int n_fail = 0;
    int cyc = 0;
    bit cur_we = 1'b0;
    bit exp_q[$];
    logic [31:0] model [32];

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
        end
    endtask

    // scoreboard monitor: read bits against queued expectations (R6, R1)
    always @(negedge clk) begin
        if (rst_n && bit_valid_o && !cur_we) begin
            if (exp_q.size() == 0) chk(1'b0, "R6 unexpected read bit", 1, 0);
            else begin
                automatic bit e = exp_q.pop_front();
                chk(rd_bit_o == e, "R6 read bit", rd_bit_o, e);
            end
        end
    end

    task automatic wait_pos(input int target);
        while ((cyc % 1024) != ((target + 1024) % 1024)) @(negedge clk);
    endtask

    task automatic do_access(input bit we, input int a, input logic [31:0] data,
                             input bit inject, input int inj_addr);
        int c_a, exp_start, nbits, waited;
        bit finished;
        @(negedge clk);
        req_i = 1'b1; we_i = we; addr_i = 5'(a);
        cur_we = we;
        c_a = cyc + 1;
        exp_start = c_a + ((32 * a - (c_a % 1024) + 1024) % 1024);
        if (!we) for (int b = 0; b < 32; b++) exp_q.push_back(model[a][b]);
        nbits = 0; waited = 0; finished = 0;
        while (!finished && waited < 1200) begin
            @(negedge clk);
            req_i = 1'b0;
            waited++;
            if (inject && waited == 3) begin
                req_i = 1'b1; we_i = 1'b1; addr_i = 5'(inj_addr); wr_bit_i = 1'b1;
            end
            if (bit_valid_o) begin
                if (nbits == 0) chk(cyc == exp_start, "R5 start time", cyc, exp_start);
                chk((cyc % 1024) == 32 * a + nbits, "R4 tap position", cyc % 1024, 32 * a + nbits);
                if (we) wr_bit_i = data[nbits];
                nbits++;
            end
            if (done_o) begin
                chk(nbits == 32, "R6 valid length", nbits, 32);
                chk(cyc == exp_start + 32, "R8 done timing", cyc, exp_start + 32);
                finished = 1;
            end
        end
        chk(finished, "R5 access completes", finished, 1);
        @(negedge clk);
        chk(!done_o, "R8 done single pulse", done_o, 0);
        if (we) model[a] = data;
        chk(exp_q.size() == 0, "R6 all bits streamed", exp_q.size(), 0);
        wr_bit_i = 1'b0;
    endtask

    task automatic rd(input int a);
        do_access(1'b0, a, 32'h0, 1'b0, 0);
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        do_access(1'b1, a, d, 1'b0, 0);
    endtask

    initial begin
        for (int i = 0; i < 32; i++) model[i] = '0;
        repeat (4) @(negedge clk);
        // R2 reset state
        chk(!bit_valid_o, "R2 valid low in reset", bit_valid_o, 0);
        chk(!done_o, "R2 done low in reset", done_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!bit_valid_o && !done_o, "R2 quiet after reset", bit_valid_o, 0);
        // R2 contents are zero
        rd(3);
        rd(31);
        // R1 R7 several patterns incl. flag/sign bits
        wr(0, 32'hFFFF_FFFF);
        wr(17, 32'h5A3C_96E1);
        wr(31, 32'hC000_0000);
        wr(5, 32'h0000_0001);
        rd(0); rd(17); rd(31); rd(5);
        rd(4); rd(6); rd(16); rd(18);
        // R5 zero wait: acceptance lands on word start
        wait_pos(32 * 17 - 2);
        rd(17);
        // R5 maximum wait: acceptance one bit past word start
        wait_pos(32 * 5 - 1);
        rd(5);
        wait_pos(-2);
        wr(0, 32'h8000_7FFE);
        rd(0);
        // R9 R7 ignored request and wr_bit during pending read
        do_access(1'b0, 20, 32'h0, 1'b1, 9);
        for (int k = 0; k < 1100; k++) begin
            @(negedge clk);
            if (bit_valid_o || done_o) begin
                chk(1'b0, "R9 ignored request caused activity", 1, 0);
                break;
            end
        end
        chk(1'b1, "R9 quiet after ignored request", 0, 0);
        rd(9);
        rd(20);
        // R1 R3 full sweep, idle periods between write and read
        for (int w = 0; w < 32; w++) wr(w, (32'h9E37_79B9 * (w + 1)) ^ 32'(w));
        repeat (3 * 1024) @(negedge clk);
        for (int w = 0; w < 32; w++) rd(w);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule